// File: doc/BRIEF.md
# SPI Word Packing FIFO Datapath

This block carries SPI words between a 32-bit register bus and a serial shift engine. Software writes outgoing words into an output queue and reads incoming words from an input queue. The shift engine pops outgoing words and pushes incoming words, one SPI word per request. The block moves words between the two alignments used on each side. On the bus, outgoing words are left-justified and incoming words are right-justified. On the shifter side, every word is right-justified and trimmed to the programmed word width.

A start pulse flushes both queues and loads the outgoing and incoming word counters from the count of the selected transfer mode, either queue mode or block mode. The block then raises sticky service and done flags as words move. It also detects overrun and underrun in both directions, holds them as sticky error flags that software clears by writing 1, and drives one interrupt from a per-source enable mask. The queue geometry comes from two size codes, and the block reports it on two constant outputs.

Top module: `wpk_datapath`

## Requirements
- R1: The word container is 1 byte for 4..8 bits per word (`cfg_bpw_m1` 3..7), 2 bytes for 9..16 bits and 4 bytes for 17..32 bits. The shifter sees the top container bytes of a bus word (bits 31:24 first), right-justified and masked to the word width. Example: 12-bit word, bus word 0xABCD1234, shifter data 0x00000BCD.
- R2: An incoming shifter word is masked to the word width and read on the bus right-justified, with zeros above it.
- R3: Both queues are first-in first-out. Status bit 4 is output not empty, bit 5 is input not empty, bit 6 is output full and bit 7 is input full.
- R4: A bus write to a full output queue drops the word and sets error bit 5 (output overrun).
- R5: A bus read of an empty input queue returns zero and sets error bit 4 (input underrun).
- R6: A shifter pop of an empty output queue returns zero and sets error bit 3 (output underrun).
- R7: A shifter push into a full input queue drops the word and sets error bit 2 (input overrun).
- R8: Error flags and status bits 8..11 are sticky. Writing 1 to a bit through its clear mask clears it. A new event in the same cycle keeps the flag set.
- R9: Start loads both counters from `cfg_fifo_words` in queue mode and from `cfg_block_words` in block mode. The count of the other mode has no effect. Status bit 10 (output done) sets when the last counted word is popped. Status bit 11 (input done) sets when the last counted word is pushed.
- R10: Status bit 8 (output service) sets on a pop that leaves counted words still to send, if the output queue is then empty (queue mode) or has at least one block of free space (block mode). Status bit 9 (input service) sets on a push that completes the count (queue mode) or that leaves at least one block in the input queue (block mode).
- R11: `irq` is the OR of the enabled sources. Enable bits 0..3 select error bits 2..5 and enable bits 4..7 select status bits 8..11.
- R12: The block size is 4 words for size code 0 and code×16 otherwise. The depth is block size × 2^(depth code+1). Both appear on `block_words` and `depth_words`.
- R13: Start empties both queues and clears status bits 8..11. It leaves the error flags unchanged, and any bus or shifter request in the same cycle is ignored.
- R14: After reset, status, error flags and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bpw_m1 | input | 5 | Bits per word minus one |
| cfg_block_mode | input | 1 | 1 selects block mode, 0 queue mode |
| cfg_fifo_words | input | 16 | Word count used in queue mode |
| cfg_block_words | input | 16 | Word count used in block mode |
| xfer_start | input | 1 | Flush queues and load counters |
| tx_wr_valid | input | 1 | Bus write to the output queue |
| tx_wr_data | input | 32 | Left-justified outgoing word |
| rx_rd_en | input | 1 | Bus read from the input queue |
| rx_rd_data | output | 32 | Right-justified incoming word, valid while rx_rd_en |
| sh_tx_req | input | 1 | Shifter pops an outgoing word |
| sh_tx_data | output | 32 | Right-justified outgoing word, valid while sh_tx_req |
| sh_rx_valid | input | 1 | Shifter pushes an incoming word |
| sh_rx_data | input | 32 | Raw incoming bits, low-aligned |
| status | output | 12 | Queue state, service and done flags |
| stat_clr_valid | input | 1 | Apply status clear mask |
| stat_clr_mask | input | 12 | Write-1-to-clear for bits 8..11 |
| err_flags | output | 6 | Sticky error flags in bits 2..5 |
| err_clr_valid | input | 1 | Apply error clear mask |
| err_clr_mask | input | 6 | Write-1-to-clear for bits 2..5 |
| irq_en | input | 8 | Interrupt enable per source |
| irq | output | 1 | Interrupt request |
| depth_words | output | 16 | Queue depth in words |
| block_words | output | 8 | Block size in words |

## Verification
The hardest situations to reach are the edges of the queues. Hitting them needs exactly depth-plus-one writes or pushes with no drain in between, followed by a full drain that proves the dropped word never entered. Events that coincide with a clear are also hard to reach. The stimulus fills each queue to its limit, then drains it against a scoreboard of the expected words. It issues an empty read in the same cycle as the clear of that error bit. In block mode it counts pops and pushes so the service and done flags are checked on the exact word that should raise them.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  // status bit positions
  localparam int ST_OUT_NE   = 4;
  localparam int ST_IN_NE    = 5;
  localparam int ST_OUT_FULL = 6;
  localparam int ST_IN_FULL  = 7;
  localparam int ST_OUT_SVC  = 8;
  localparam int ST_IN_SVC   = 9;
  localparam int ST_OUT_DONE = 10;
  localparam int ST_IN_DONE  = 11;
  // error bit positions
  localparam int ER_IN_OVR   = 2;
  localparam int ER_OUT_UNR  = 3;
  localparam int ER_IN_UNR   = 4;
  localparam int ER_OUT_OVR  = 5;

  typedef enum logic [1:0] {
    CNT_ONE  = 2'd0,
    CNT_TWO  = 2'd1,
    CNT_FOUR = 2'd2
  } cont_e;

  function automatic cont_e container_of(input logic [4:0] bpw_m1);
    if (bpw_m1 <= 5'd7)       return CNT_ONE;
    else if (bpw_m1 <= 5'd15) return CNT_TWO;
    else                      return CNT_FOUR;
  endfunction

  function automatic logic [31:0] width_mask(input logic [4:0] bpw_m1);
    return 32'hFFFF_FFFF >> (5'd31 - bpw_m1);
  endfunction
endpackage

// File: rtl/wpk_fifo.sv
module wpk_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int CNTW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic [CNTW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [CNTW-1:0] cnt_n;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_n    = count;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (push) wr_ptr_n = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr_n = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      cnt_n = count + 1'b1;
      else if (pop && !push) cnt_n = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/wpk_align.sv
module wpk_align
  import wpk_pkg::*;
(
  input  logic [4:0]  bpw_m1,
  input  logic [31:0] tx_bus_word,
  output logic [31:0] tx_shift_word,
  input  logic [31:0] rx_raw,
  output logic [31:0] rx_bus_word
);
  cont_e       cont;
  logic [31:0] mask;
  logic [31:0] tx_just;

  always_comb begin
    cont = container_of(bpw_m1);
    mask = width_mask(bpw_m1);
    unique case (cont)
      CNT_ONE:  tx_just = {24'd0, tx_bus_word[31:24]};
      CNT_TWO:  tx_just = {16'd0, tx_bus_word[31:16]};
      default:  tx_just = tx_bus_word;
    endcase
    tx_shift_word = tx_just & mask;
    rx_bus_word   = rx_raw & mask;
  end
endmodule

// File: rtl/wpk_ctl.sv
module wpk_ctl
  import wpk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BLK   = 4,
  parameter int CNTW  = 5,
  parameter int XW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            block_mode,
  input  logic [XW-1:0]   fifo_words,
  input  logic [XW-1:0]   block_words,
  input  logic            tx_try,
  input  logic            rx_try,
  input  logic            sh_pop_try,
  input  logic            sh_push_try,
  input  logic [CNTW-1:0] out_cnt,
  input  logic [CNTW-1:0] in_cnt,
  input  logic            stat_clr_valid,
  input  logic [11:0]     stat_clr_mask,
  input  logic            err_clr_valid,
  input  logic [5:0]      err_clr_mask,
  input  logic [7:0]      irq_en,
  output logic            out_push,
  output logic            out_pop,
  output logic            in_push,
  output logic            in_pop,
  output logic [11:0]     status,
  output logic [5:0]      err_flags,
  output logic            irq
);
  localparam logic [CNTW-1:0] FULL_LVL = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] BLK_LVL  = CNTW'(BLK);
  localparam logic [CNTW-1:0] SVC_LVL  = CNTW'(DEPTH - BLK);

  logic [XW-1:0]   out_rem, in_rem, out_rem_n, in_rem_n, load_val;
  logic [3:0]      sd, sd_n, sd_set, sd_clr;   // out_svc, in_svc, out_done, in_done
  logic [3:0]      er, er_n, er_set, er_clr;   // in_ovr, out_unr, in_unr, out_ovr
  logic [CNTW-1:0] out_occ_n, in_occ_n;
  logic            out_full, out_empty, in_full, in_empty;
  logic            out_svc_set, in_svc_set;

  always_comb begin
    out_full  = (out_cnt == FULL_LVL);
    out_empty = (out_cnt == '0);
    in_full   = (in_cnt == FULL_LVL);
    in_empty  = (in_cnt == '0);

    out_push = tx_try      && !start && !out_full;
    out_pop  = sh_pop_try  && !start && !out_empty;
    in_push  = sh_push_try && !start && !in_full;
    in_pop   = rx_try      && !start && !in_empty;

    out_occ_n = out_cnt + CNTW'(out_push) - CNTW'(out_pop);
    in_occ_n  = in_cnt  + CNTW'(in_push)  - CNTW'(in_pop);

    load_val  = block_mode ? block_words : fifo_words;
    out_rem_n = out_rem;
    in_rem_n  = in_rem;
    if (start) begin
      out_rem_n = load_val;
      in_rem_n  = load_val;
    end else begin
      if (out_pop && out_rem != '0) out_rem_n = out_rem - 1'b1;
      if (in_push && in_rem != '0)  in_rem_n  = in_rem - 1'b1;
    end

    out_svc_set = out_pop && (out_rem_n != '0) &&
                  (block_mode ? (out_occ_n <= SVC_LVL) : (out_occ_n == '0));
    in_svc_set  = in_push &&
                  (block_mode ? (in_occ_n >= BLK_LVL)
                              : (in_rem == XW'(1)));

    sd_set = {in_push && (in_rem == XW'(1)),
              out_pop && (out_rem == XW'(1)),
              in_svc_set, out_svc_set};
    sd_clr = stat_clr_valid ? stat_clr_mask[11:8] : 4'b0;
    sd_n   = start ? 4'b0 : ((sd & ~sd_clr) | sd_set);

    er_set = {tx_try      && !start && out_full,
              rx_try      && !start && in_empty,
              sh_pop_try  && !start && out_empty,
              sh_push_try && !start && in_full};
    er_clr = err_clr_valid ? err_clr_mask[5:2] : 4'b0;
    er_n   = (er & ~er_clr) | er_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_rem <= '0;
      in_rem  <= '0;
      sd      <= '0;
      er      <= '0;
    end else begin
      out_rem <= out_rem_n;
      in_rem  <= in_rem_n;
      sd      <= sd_n;
      er      <= er_n;
    end
  end

  always_comb begin
    status = '0;
    status[ST_OUT_NE]   = !out_empty;
    status[ST_IN_NE]    = !in_empty;
    status[ST_OUT_FULL] = out_full;
    status[ST_IN_FULL]  = in_full;
    status[11:8]        = sd;
    err_flags           = {er, 2'b00};
    irq                 = |({sd, er} & irq_en);
  end
endmodule

// File: rtl/wpk_datapath.sv
module wpk_datapath #(
  parameter int BLK_CODE  = 0,
  parameter int FIFO_CODE = 1,
  parameter int XW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    cfg_bpw_m1,
  input  logic          cfg_block_mode,
  input  logic [XW-1:0] cfg_fifo_words,
  input  logic [XW-1:0] cfg_block_words,
  input  logic          xfer_start,
  input  logic          tx_wr_valid,
  input  logic [31:0]   tx_wr_data,
  input  logic          rx_rd_en,
  output logic [31:0]   rx_rd_data,
  input  logic          sh_tx_req,
  output logic [31:0]   sh_tx_data,
  input  logic          sh_rx_valid,
  input  logic [31:0]   sh_rx_data,
  output logic [11:0]   status,
  input  logic          stat_clr_valid,
  input  logic [11:0]   stat_clr_mask,
  output logic [5:0]    err_flags,
  input  logic          err_clr_valid,
  input  logic [5:0]    err_clr_mask,
  input  logic [7:0]    irq_en,
  output logic          irq,
  output logic [15:0]   depth_words,
  output logic [7:0]    block_words
);
  localparam int BLK   = (BLK_CODE == 0) ? 4 : BLK_CODE * 16;
  localparam int DEPTH = BLK * (2 << FIFO_CODE);
  localparam int CNTW  = $clog2(DEPTH + 1);

  logic            out_push, out_pop, in_push, in_pop;
  logic [CNTW-1:0] out_cnt, in_cnt;
  logic [31:0]     out_head, in_head, tx_aligned, rx_aligned;

  wpk_fifo #(.W(32), .DEPTH(DEPTH), .CNTW(CNTW)) u_out_q (
    .clk(clk), .rst_n(rst_n), .flush(xfer_start),
    .push(out_push), .push_data(tx_wr_data),
    .pop(out_pop), .head(out_head), .count(out_cnt)
  );

  wpk_fifo #(.W(32), .DEPTH(DEPTH), .CNTW(CNTW)) u_in_q (
    .clk(clk), .rst_n(rst_n), .flush(xfer_start),
    .push(in_push), .push_data(rx_aligned),
    .pop(in_pop), .head(in_head), .count(in_cnt)
  );

  wpk_align u_align (
    .bpw_m1(cfg_bpw_m1),
    .tx_bus_word(out_head), .tx_shift_word(tx_aligned),
    .rx_raw(sh_rx_data), .rx_bus_word(rx_aligned)
  );

  wpk_ctl #(.DEPTH(DEPTH), .BLK(BLK), .CNTW(CNTW), .XW(XW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(xfer_start),
    .block_mode(cfg_block_mode),
    .fifo_words(cfg_fifo_words), .block_words(cfg_block_words),
    .tx_try(tx_wr_valid), .rx_try(rx_rd_en),
    .sh_pop_try(sh_tx_req), .sh_push_try(sh_rx_valid),
    .out_cnt(out_cnt), .in_cnt(in_cnt),
    .stat_clr_valid(stat_clr_valid), .stat_clr_mask(stat_clr_mask),
    .err_clr_valid(err_clr_valid), .err_clr_mask(err_clr_mask),
    .irq_en(irq_en),
    .out_push(out_push), .out_pop(out_pop),
    .in_push(in_push), .in_pop(in_pop),
    .status(status), .err_flags(err_flags), .irq(irq)
  );

  assign rx_rd_data  = (in_cnt == '0)  ? 32'd0 : in_head;
  assign sh_tx_data  = (out_cnt == '0) ? 32'd0 : tx_aligned;
  assign depth_words = 16'(DEPTH);
  assign block_words = 8'(BLK);
endmodule

// File: rtl/wpk_checker.sv
module wpk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_start,
  input logic        tx_wr_valid,
  input logic        rx_rd_en,
  input logic [31:0] rx_rd_data,
  input logic        sh_tx_req,
  input logic        sh_rx_valid,
  input logic [11:0] status,
  input logic [5:0]  err_flags,
  input logic        err_clr_valid,
  input logic [5:0]  err_clr_mask,
  input logic [7:0]  irq_en,
  input logic        irq
);
  a_r3_out_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[4]);
  a_r3_in_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> status[5]);
  a_r4_out_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_valid && status[6] && !xfer_start |=> err_flags[5]);
  a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_en && !status[5] |-> rx_rd_data == 32'd0);
  a_r6_out_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    sh_tx_req && !status[4] && !xfer_start |=> err_flags[3]);
  a_r7_in_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    sh_rx_valid && status[7] && !xfer_start |=> err_flags[2]);
  a_r8_sticky_error: assert property (@(posedge clk) disable iff (!rst_n)
    err_flags[3] && !(err_clr_valid && err_clr_mask[3]) |=> err_flags[3]);
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en == 8'd0 |-> !irq);
endmodule

bind wpk_datapath wpk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
  .tx_wr_valid(tx_wr_valid), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
  .sh_tx_req(sh_tx_req), .sh_rx_valid(sh_rx_valid),
  .status(status), .err_flags(err_flags),
  .err_clr_valid(err_clr_valid), .err_clr_mask(err_clr_mask),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_wpk_datapath.sv
`timescale 1ns/1ps
module tb_wpk_datapath;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cfg_bpw_m1;
  logic        cfg_block_mode;
  logic [15:0] cfg_fifo_words, cfg_block_words;
  logic        xfer_start, tx_wr_valid, rx_rd_en, sh_tx_req, sh_rx_valid;
  logic [31:0] tx_wr_data, rx_rd_data, sh_tx_data, sh_rx_data;
  logic [11:0] status, stat_clr_mask;
  logic        stat_clr_valid, err_clr_valid, irq;
  logic [5:0]  err_flags, err_clr_mask;
  logic [7:0]  irq_en, block_words;
  logic [15:0] depth_words;

  int checks = 0;
  int fails  = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  always #2 clk = ~clk;

  wpk_datapath dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: bus write, expected shifter word queued when accepted
  task automatic bus_write(input logic [31:0] d, input logic [31:0] exp_sh, input bit keep);
    tx_wr_valid = 1'b1; tx_wr_data = d;
    tick();
    tx_wr_valid = 1'b0;
    if (keep) txq.push_back(exp_sh);
  endtask

  // monitor: shifter pop compared against scoreboard
  task automatic tx_pop(input string req);
    logic [31:0] exp;
    sh_tx_req = 1'b1;
    #1;
    exp = (txq.size() != 0) ? txq.pop_front() : 32'd0;
    chk(req, sh_tx_data, exp);
    tick();
    sh_tx_req = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] raw, input logic [31:0] exp_bus, input bit keep);
    sh_rx_valid = 1'b1; sh_rx_data = raw;
    tick();
    sh_rx_valid = 1'b0;
    if (keep) rxq.push_back(exp_bus);
  endtask

  task automatic bus_read(input string req);
    logic [31:0] exp;
    rx_rd_en = 1'b1;
    #1;
    exp = (rxq.size() != 0) ? rxq.pop_front() : 32'd0;
    chk(req, rx_rd_data, exp);
    tick();
    rx_rd_en = 1'b0;
  endtask

  task automatic start(input logic mode, input logic [15:0] fw, input logic [15:0] bw);
    cfg_block_mode = mode; cfg_fifo_words = fw; cfg_block_words = bw;
    xfer_start = 1'b1;
    tick();
    xfer_start = 1'b0;
    txq.delete(); rxq.delete();
  endtask

  task automatic clr_status(input logic [11:0] m);
    stat_clr_valid = 1'b1; stat_clr_mask = m;
    tick();
    stat_clr_valid = 1'b0;
  endtask

  task automatic clr_err(input logic [5:0] m);
    err_clr_valid = 1'b1; err_clr_mask = m;
    tick();
    err_clr_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    report();
  end

  initial begin
    rst_n = 1'b0;
    cfg_bpw_m1 = 5'd7; cfg_block_mode = 1'b0;
    cfg_fifo_words = '0; cfg_block_words = '0;
    xfer_start = 0; tx_wr_valid = 0; rx_rd_en = 0; sh_tx_req = 0; sh_rx_valid = 0;
    tx_wr_data = '0; sh_rx_data = '0;
    stat_clr_valid = 0; stat_clr_mask = '0; err_clr_valid = 0; err_clr_mask = '0;
    irq_en = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R14 reset state, R12 geometry
    chk("R14 status", 32'(status), 32'd0);
    chk("R14 err", 32'(err_flags), 32'd0);
    chk("R14 irq", 32'(irq), 32'd0);
    chk("R12 depth", 32'(depth_words), 32'd16);
    chk("R12 block", 32'(block_words), 32'd4);
    irq_en = 8'h00;

    // R1 8-bit words, R9 queue-mode count, other count ignored
    start(1'b0, 16'd3, 16'd99);
    bus_write(32'hA5112233, 32'h000000A5, 1);
    bus_write(32'h3C000000, 32'h0000003C, 1);
    bus_write(32'hFF00FF00, 32'h000000FF, 1);
    chk("R3 out not empty", 32'(status[4]), 32'd1);
    tx_pop("R1 8-bit"); tx_pop("R1 8-bit");
    chk("R9 no early done", 32'(status[10]), 32'd0);
    tx_pop("R1 8-bit");
    chk("R9 out done queue mode", 32'(status[10]), 32'd1);
    chk("R3 out empty", 32'(status[4]), 32'd0);

    // R1 other widths
    cfg_bpw_m1 = 5'd11; bus_write(32'hABCD1234, 32'h00000BCD, 1); tx_pop("R1 12-bit");
    cfg_bpw_m1 = 5'd31; bus_write(32'hDEADBEEF, 32'hDEADBEEF, 1); tx_pop("R1 32-bit");
    cfg_bpw_m1 = 5'd3;  bus_write(32'h9F000000, 32'h0000000F, 1); tx_pop("R1 4-bit");
    cfg_bpw_m1 = 5'd19; bus_write(32'h12345678, 32'h00045678, 1); tx_pop("R1 20-bit");

    // R2 receive alignment
    cfg_bpw_m1 = 5'd11; rx_push(32'hFFFFFABC, 32'h00000ABC, 1);
    cfg_bpw_m1 = 5'd7;  rx_push(32'h12345678, 32'h00000078, 1);
    chk("R3 in not empty", 32'(status[5]), 32'd1);
    bus_read("R2 12-bit"); bus_read("R2 8-bit");

    // R5 empty read, R11 interrupt enable
    bus_read("R5 empty data");
    chk("R5 in underrun flag", 32'(err_flags[4]), 32'd1);
    chk("R11 irq masked", 32'(irq), 32'd0);
    irq_en = 8'h04; #1;
    chk("R11 irq enabled", 32'(irq), 32'd1);
    irq_en = 8'h00;
    // R8 set wins over clear in the same cycle
    rx_rd_en = 1'b1; err_clr_valid = 1'b1; err_clr_mask = 6'h10;
    tick();
    rx_rd_en = 1'b0; err_clr_valid = 1'b0;
    chk("R8 set wins", 32'(err_flags[4]), 32'd1);
    clr_err(6'h10);
    chk("R8 clear", 32'(err_flags[4]), 32'd0);

    // R4 output overrun, R3 order at full depth
    cfg_bpw_m1 = 5'd31;
    for (int i = 0; i < 16; i++) bus_write(32'hC0DE0000 + 32'(i), 32'hC0DE0000 + 32'(i), 1);
    chk("R3 out full", 32'(status[6]), 32'd1);
    chk("R4 no flag before", 32'(err_flags[5]), 32'd0);
    bus_write(32'hBAD0BAD0, 32'h0, 0);
    chk("R4 out overrun flag", 32'(err_flags[5]), 32'd1);
    for (int i = 0; i < 16; i++) tx_pop("R3 R4 order");
    chk("R4 dropped word absent", 32'(status[4]), 32'd0);

    // R6 output underrun
    tx_pop("R6 empty pop data");
    chk("R6 out underrun flag", 32'(err_flags[3]), 32'd1);

    // R7 input overrun
    for (int i = 0; i < 16; i++) rx_push(32'h5A000000 + 32'(i), 32'h5A000000 + 32'(i), 1);
    chk("R3 in full", 32'(status[7]), 32'd1);
    rx_push(32'hBAD1BAD1, 32'h0, 0);
    chk("R7 in overrun flag", 32'(err_flags[2]), 32'd1);
    for (int i = 0; i < 16; i++) bus_read("R7 order");
    chk("R7 dropped word absent", 32'(status[5]), 32'd0);

    // R9 R10 block mode
    start(1'b1, 16'd2, 16'd6);
    for (int i = 0; i < 6; i++) bus_write(32'h0B000000 + 32'(i), 32'h0B000000 + 32'(i), 1);
    tx_pop("R10 data");
    chk("R10 out service block", 32'(status[8]), 32'd1);
    clr_status(12'h100);
    chk("R8 status clear", 32'(status[8]), 32'd0);
    tx_pop("R9 data");
    chk("R9 fifo count ignored", 32'(status[10]), 32'd0);
    for (int i = 0; i < 4; i++) tx_pop("R9 data");
    chk("R9 out done block", 32'(status[10]), 32'd1);
    irq_en = 8'h10; #1;
    chk("R11 irq from service", 32'(irq), 32'd1);
    irq_en = 8'h00;
    for (int i = 0; i < 3; i++) rx_push(32'(i), 32'(i), 1);
    chk("R10 no in service yet", 32'(status[9]), 32'd0);
    rx_push(32'd3, 32'd3, 1);
    chk("R10 in service block", 32'(status[9]), 32'd1);
    rx_push(32'd4, 32'd4, 1);
    chk("R9 no early in done", 32'(status[11]), 32'd0);
    rx_push(32'd5, 32'd5, 1);
    chk("R9 in done block", 32'(status[11]), 32'd1);

    // R13 start flushes and keeps errors
    start(1'b0, 16'd1, 16'd1);
    chk("R13 flags cleared", 32'(status[11:4]), 32'd0);
    chk("R13 errors kept", 32'(err_flags[5]), 32'd1);
    bus_read("R13 queue emptied");
    clr_err(6'h3C);
    chk("R8 all cleared", 32'(err_flags), 32'd0);

    report();
  end
endmodule